// File: doc/BRIEF.md
# Privileged Status Register and Trap State Unit

This block keeps the 64-bit machine status word of a three-level RISC-V style core together with the current privilege mode. Four single-cycle pulses from the pipeline tell it that a trap was taken into machine mode, a trap was taken into supervisor mode, a supervisor return retired, or a machine return retired. On each pulse it updates, in one clock, the stacked interrupt-enable bits, the saved previous-privilege fields and the mode itself.

A CSR port reads and writes the status word. It has two views. The machine view covers all 64 bits. The supervisor view is a masked alias onto a fixed subset of the same bits.

The outputs are:
- the current mode, which also serves as the instruction-fetch privilege;
- one bit saying whether interrupts are globally allowed in that mode;
- the effective privilege for data loads and stores, which the modify-privilege bit can redirect to the saved machine previous privilege.

Top module: `priv_status_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the mode becomes machine (2'b11) and all 64 status bits become zero.
- R2: Modes are encoded as 2'b00 user, 2'b01 supervisor and 2'b11 machine. Status fields sit at these bits: machine interrupt enable at 3, machine previous enable at 7, machine previous privilege at 12:11, modify-privilege at 17, supervisor interrupt enable at 1, supervisor previous enable at 5, and supervisor previous privilege at 8. `csr_sel_s_i`=0 selects the machine view, in which a write stores all 64 bits of `csr_wdata_i` at the next edge. The read data always shows the selected view of the current register.
- R3: With `csr_sel_s_i`=1, the read data shows only bits 63, 33:32, 19, 18, 16:13, 8, 6, 5 and 1 of the status word, and every other bit reads 0. A write through this view changes only those bits and leaves all other bits unchanged.
- R4: A supervisor trap pulse makes the mode supervisor. In the same edge it copies the old supervisor enable into the supervisor previous enable, clears the supervisor enable, and sets the supervisor previous privilege to 0 if the old mode was user and to 1 otherwise.
- R5: A machine trap pulse makes the mode machine. In the same edge it copies the old machine enable into the machine previous enable, clears the machine enable, and stores the old mode in the machine previous privilege field.
- R6: A supervisor return sets the mode to supervisor if the supervisor previous privilege is 1 and to user if it is 0. It also clears modify-privilege, loads the supervisor enable from the supervisor previous enable, sets the supervisor previous enable to 1, and clears the supervisor previous privilege.
- R7: A machine return sets the mode to the machine previous privilege field. It clears modify-privilege unless that field held machine. It also loads the machine enable from the machine previous enable, sets the machine previous enable to 1, and sets the field to user (2'b00).
- R8: `irq_global_en_o` is the machine enable bit in machine mode, the supervisor enable bit in supervisor mode, and 1 in user mode.
- R9: `data_priv_o` equals the machine previous privilege field when modify-privilege is 1, and equals the current mode otherwise.
- R10: In a single cycle, these priorities apply:
  - a machine trap wins over a supervisor trap;
  - any trap wins over either return;
  - a machine return wins over a supervisor return;
  - any trap or return pulse discards a CSR write in the same cycle.
- R11: A machine-view write whose bits 12:11 are 2'b10 leaves the machine previous privilege field unchanged, while the other bits are written. The field never holds 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_m_i | input | 1 | Pulse: trap taken into machine mode |
| trap_s_i | input | 1 | Pulse: trap taken into supervisor mode |
| sret_i | input | 1 | Pulse: supervisor return retires |
| mret_i | input | 1 | Pulse: machine return retires |
| csr_we_i | input | 1 | CSR write strobe |
| csr_sel_s_i | input | 1 | CSR view select: 0 machine, 1 supervisor |
| csr_wdata_i | input | 64 | CSR write data |
| csr_rdata_o | output | 64 | CSR read data of the selected view |
| mode_o | output | 2 | Current privilege mode, also the fetch privilege |
| irq_global_en_o | output | 1 | Interrupts globally allowed in the current mode |
| data_priv_o | output | 2 | Effective privilege for loads and stores |

## Verification
The bench targets several corner cases:
- Simultaneous pulses. A unit with the wrong priority would take the supervisor trap over the machine trap, perform the supervisor return in place of the machine return, or let a CSR write land on top of a trap update.
- A machine return whose saved privilege is machine. It must keep modify-privilege set. A design that cleared it unconditionally would drop the redirected data privilege.
- A supervisor trap taken from user mode, which must save 0 as the previous privilege.
- A supervisor-view write of all ones. This exposes a mask that reaches the machine-only fields.
- A machine-view write carrying the reserved privilege code 2'b10. A design that stored it would later return into an undefined mode.

// File: rtl/priv_pkg.sv
package priv_pkg;

    localparam int XLEN     = 64;
    localparam int PRIV_W   = 2;

    // Machine status field positions
    localparam int B_MIE    = 3;
    localparam int B_MPIE   = 7;
    localparam int B_MPP_LO = 11;
    localparam int B_MPP_HI = B_MPP_LO + PRIV_W - 1;
    localparam int B_MPRV   = 17;

    // Supervisor status field positions
    localparam int B_SIE    = 1;
    localparam int B_SPIE   = 5;
    localparam int B_SPP    = 8;

    typedef enum logic [PRIV_W-1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    localparam logic [PRIV_W-1:0] PRIV_RSVD = 2'b10;

    typedef struct packed {
        logic trap_m;
        logic trap_s;
        logic mret;
        logic sret;
    } priv_evt_t;

    // Bits of the machine word that the supervisor view aliases
    function automatic logic [XLEN-1:0] sview_mask();
        logic [XLEN-1:0] m;
        m = '0;
        m[B_SIE]  = 1'b1;
        m[B_SPIE] = 1'b1;
        m[6]      = 1'b1;
        m[B_SPP]  = 1'b1;
        for (int i = 13; i <= 16; i++) m[i] = 1'b1;
        m[18]     = 1'b1;
        m[19]     = 1'b1;
        m[32]     = 1'b1;
        m[33]     = 1'b1;
        m[XLEN-1] = 1'b1;
        return m;
    endfunction

    localparam logic [XLEN-1:0] SVIEW_MASK = sview_mask();

endpackage

// File: rtl/priv_event_update.sv
module priv_event_update
    import priv_pkg::*;
(
    input  logic [XLEN-1:0] cur_status,
    input  priv_e           cur_mode,
    input  priv_evt_t       evt,
    output logic [XLEN-1:0] nxt_status,
    output priv_e           nxt_mode,
    output logic            evt_active
);

    logic [PRIV_W-1:0] saved_mpp;
    assign saved_mpp = cur_status[B_MPP_HI:B_MPP_LO];

    always_comb begin
        nxt_status = cur_status;
        nxt_mode   = cur_mode;
        evt_active = 1'b1;
        if (evt.trap_m) begin
            nxt_status[B_MPIE]            = cur_status[B_MIE];
            nxt_status[B_MIE]             = 1'b0;
            nxt_status[B_MPP_HI:B_MPP_LO] = cur_mode;
            nxt_mode                      = PRIV_M;
        end else if (evt.trap_s) begin
            nxt_status[B_SPIE] = cur_status[B_SIE];
            nxt_status[B_SIE]  = 1'b0;
            nxt_status[B_SPP]  = (cur_mode != PRIV_U);
            nxt_mode           = PRIV_S;
        end else if (evt.mret) begin
            nxt_mode = priv_e'(saved_mpp);
            if (saved_mpp != PRIV_M) nxt_status[B_MPRV] = 1'b0;
            nxt_status[B_MIE]             = cur_status[B_MPIE];
            nxt_status[B_MPIE]            = 1'b1;
            nxt_status[B_MPP_HI:B_MPP_LO] = PRIV_U;
        end else if (evt.sret) begin
            nxt_mode            = cur_status[B_SPP] ? PRIV_S : PRIV_U;
            nxt_status[B_MPRV]  = 1'b0;
            nxt_status[B_SIE]   = cur_status[B_SPIE];
            nxt_status[B_SPIE]  = 1'b1;
            nxt_status[B_SPP]   = 1'b0;
        end else begin
            evt_active = 1'b0;
        end
    end

endmodule

// File: rtl/priv_csr_view.sv
module priv_csr_view
    import priv_pkg::*;
(
    input  logic [XLEN-1:0] status,
    input  logic            sel_s,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] wr_status
);

    assign rdata = sel_s ? (status & SVIEW_MASK) : status;

    always_comb begin
        if (sel_s) begin
            wr_status = (status & ~SVIEW_MASK) | (wdata & SVIEW_MASK);
        end else begin
            wr_status = wdata;
            if (wdata[B_MPP_HI:B_MPP_LO] == PRIV_RSVD)
                wr_status[B_MPP_HI:B_MPP_LO] = status[B_MPP_HI:B_MPP_LO];
        end
    end

endmodule

// File: rtl/priv_status_unit.sv
module priv_status_unit
    import priv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_m_i,
    input  logic              trap_s_i,
    input  logic              sret_i,
    input  logic              mret_i,
    input  logic              csr_we_i,
    input  logic              csr_sel_s_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic [PRIV_W-1:0] mode_o,
    output logic              irq_global_en_o,
    output logic [PRIV_W-1:0] data_priv_o
);

    logic [XLEN-1:0] status_q;
    priv_e           mode_q;
    priv_evt_t       evt;
    logic [XLEN-1:0] evt_status;
    priv_e           evt_mode;
    logic            evt_active;
    logic [XLEN-1:0] csr_status;

    assign evt = '{trap_m: trap_m_i, trap_s: trap_s_i, mret: mret_i, sret: sret_i};

    priv_event_update u_evt (
        .cur_status (status_q),
        .cur_mode   (mode_q),
        .evt        (evt),
        .nxt_status (evt_status),
        .nxt_mode   (evt_mode),
        .evt_active (evt_active)
    );

    priv_csr_view u_view (
        .status    (status_q),
        .sel_s     (csr_sel_s_i),
        .wdata     (csr_wdata_i),
        .rdata     (csr_rdata_o),
        .wr_status (csr_status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mode_q   <= PRIV_M;
        end else if (evt_active) begin
            status_q <= evt_status;
            mode_q   <= evt_mode;
        end else if (csr_we_i) begin
            status_q <= csr_status;
        end
    end

    always_comb begin
        unique case (mode_q)
            PRIV_M:  irq_global_en_o = status_q[B_MIE];
            PRIV_S:  irq_global_en_o = status_q[B_SIE];
            default: irq_global_en_o = 1'b1;
        endcase
    end

    assign mode_o      = mode_q;
    assign data_priv_o = status_q[B_MPRV] ? status_q[B_MPP_HI:B_MPP_LO] : mode_q;

    // Trap into machine mode stacks the enable and saves the old mode
    AST_MTRAP_STACK: assert property (@(posedge clk) disable iff (rst)
        trap_m_i |=> (mode_q == PRIV_M) && !status_q[B_MIE]
                     && (status_q[B_MPIE] == $past(status_q[B_MIE]))
                     && (status_q[B_MPP_HI:B_MPP_LO] == $past(mode_q))); // R5

    // Trap into supervisor mode
    AST_STRAP_STACK: assert property (@(posedge clk) disable iff (rst)
        (trap_s_i && !trap_m_i) |=> (mode_q == PRIV_S) && !status_q[B_SIE]
                     && (status_q[B_SPIE] == $past(status_q[B_SIE]))
                     && (status_q[B_SPP] == ($past(mode_q) != PRIV_U))); // R4

    // Machine return unstacks
    AST_MRET_UNSTACK: assert property (@(posedge clk) disable iff (rst)
        (mret_i && !trap_m_i && !trap_s_i) |=>
            (mode_q == $past(status_q[B_MPP_HI:B_MPP_LO])) && status_q[B_MPIE]
            && (status_q[B_MIE] == $past(status_q[B_MPIE]))
            && (status_q[B_MPP_HI:B_MPP_LO] == PRIV_U)); // R7

    // Supervisor return unstacks and drops modify-privilege
    AST_SRET_UNSTACK: assert property (@(posedge clk) disable iff (rst)
        (sret_i && !mret_i && !trap_m_i && !trap_s_i) |=>
            (mode_q == ($past(status_q[B_SPP]) ? PRIV_S : PRIV_U))
            && !status_q[B_MPRV] && status_q[B_SPIE] && !status_q[B_SPP]
            && (status_q[B_SIE] == $past(status_q[B_SPIE]))); // R6

    // Supervisor-view writes leave machine-only bits alone
    AST_SVIEW_WRITE_MASKED: assert property (@(posedge clk) disable iff (rst)
        (csr_we_i && csr_sel_s_i && !trap_m_i && !trap_s_i && !mret_i && !sret_i) |=>
            ((status_q & ~SVIEW_MASK) == $past(status_q & ~SVIEW_MASK))); // R3

    // Reserved previous-privilege code is never held
    AST_MPP_LEGAL: assert property (@(posedge clk) disable iff (rst)
        status_q[B_MPP_HI:B_MPP_LO] != PRIV_RSVD); // R11

endmodule

// File: tb/sim_priv_status_unit.sv
`timescale 1ns/100ps
module sim_priv_status_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_m_i = 1'b0, trap_s_i = 1'b0, sret_i = 1'b0, mret_i = 1'b0;
    logic        csr_we_i = 1'b0, csr_sel_s_i = 1'b0;
    logic [63:0] csr_wdata_i = '0;
    logic [63:0] csr_rdata_o;
    logic [1:0]  mode_o;
    logic        irq_global_en_o;
    logic [1:0]  data_priv_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;   // 250 MHz

    priv_status_unit u0 (
        .clk(clk), .rst(rst),
        .trap_m_i(trap_m_i), .trap_s_i(trap_s_i), .sret_i(sret_i), .mret_i(mret_i),
        .csr_we_i(csr_we_i), .csr_sel_s_i(csr_sel_s_i), .csr_wdata_i(csr_wdata_i),
        .csr_rdata_o(csr_rdata_o), .mode_o(mode_o),
        .irq_global_en_o(irq_global_en_o), .data_priv_o(data_priv_o)
    );

    // ctl = {trap_m, trap_s, sret, mret, we, sel_s}
    typedef struct packed {
        logic [7:0]  req;
        logic [5:0]  ctl;
        logic [63:0] wd;
        logic [1:0]  em;
        logic [63:0] es;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t TBL [NVEC] = '{
        '{8'd2,  6'b000010, 64'h88,                  2'd3, 64'h88},                  // R2 machine write
        '{8'd2,  6'b000010, 64'h888,                 2'd3, 64'h888},                 // R2 MPP=S
        '{8'd7,  6'b000100, 64'h0,                   2'd1, 64'h88},                  // R7 return to S
        '{8'd3,  6'b000011, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 64'h8000_0003_000D_E1EA}, // R3 all ones via S view
        '{8'd3,  6'b000011, 64'h22,                  2'd1, 64'hAA},                  // R3
        '{8'd4,  6'b010000, 64'h0,                   2'd1, 64'h1A8},                 // R4 from S
        '{8'd6,  6'b001000, 64'h0,                   2'd1, 64'hAA},                  // R6 back to S
        '{8'd5,  6'b100000, 64'h0,                   2'd3, 64'h8A2},                 // R5 from S
        '{8'd9,  6'b000010, 64'h200A2,               2'd3, 64'h200A2},               // R9 MPRV, MPP=U
        '{8'd7,  6'b000100, 64'h0,                   2'd0, 64'hAA},                  // R7 to U, MPRV clears
        '{8'd4,  6'b010000, 64'h0,                   2'd1, 64'hA8},                  // R4 from U, SPP=0
        '{8'd10, 6'b101010, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 64'h8A0},                 // R10 trap over sret/write
        '{8'd10, 6'b110000, 64'h0,                   2'd3, 64'h1820},                // R10 M trap over S trap
        '{8'd10, 6'b001100, 64'h0,                   2'd3, 64'hA0},                  // R10 mret over sret
        '{8'd11, 6'b000010, 64'h1008,                2'd3, 64'h8},                   // R11 reserved MPP
        '{8'd9,  6'b000010, 64'h21808,               2'd3, 64'h21808},               // R9
        '{8'd7,  6'b000100, 64'h0,                   2'd3, 64'h20080},               // R7 MPRV kept
        '{8'd9,  6'b000010, 64'h20988,               2'd3, 64'h20988},               // R9 MPP=S
        '{8'd6,  6'b001000, 64'h0,                   2'd1, 64'h8A8},                 // R6 MPRV clears
        '{8'd8,  6'b000011, 64'h2,                   2'd1, 64'h88A}                  // R8 SIE on in S
    };

    function automatic logic [63:0] tb_mask();
        int bl [16] = '{1, 5, 6, 8, 13, 14, 15, 16, 18, 19, 32, 33, 63, 63, 63, 63};
        logic [63:0] m = '0;
        foreach (bl[i]) m[bl[i]] = 1'b1;
        return m;
    endfunction

    function automatic logic exp_irq(logic [1:0] md, logic [63:0] st);
        if (md == 2'b11) return st[3];
        if (md == 2'b01) return st[1];
        return 1'b1;
    endfunction

    function automatic logic [1:0] exp_dpriv(logic [1:0] md, logic [63:0] st);
        return st[17] ? st[12:11] : md;
    endfunction

    task automatic chk(input int req, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL R%0d %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic check_state(input int req, input logic [1:0] em, input logic [63:0] es);
        chk(req, "mode", {62'd0, mode_o}, {62'd0, em});
        chk(req, "status", csr_rdata_o, es);
        chk(req, "irq_en", {63'd0, irq_global_en_o}, {63'd0, exp_irq(em, es)});
        chk(req, "data_priv", {62'd0, data_priv_o}, {62'd0, exp_dpriv(em, es)});
    endtask

    task automatic apply(input logic [5:0] ctl, input logic [63:0] wd);
        @(negedge clk);
        {trap_m_i, trap_s_i, sret_i, mret_i, csr_we_i, csr_sel_s_i} = ctl;
        csr_wdata_i = wd;
        @(posedge clk);
        #0.5;
        {trap_m_i, trap_s_i, sret_i, mret_i, csr_we_i, csr_sel_s_i} = '0;
        csr_wdata_i = '0;
        #0.5;
    endtask

    initial begin
        #(4 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] mask;
        mask = tb_mask();
        repeat (3) @(posedge clk);
        #0.5;
        rst = 1'b0;
        #0.5;
        check_state(1, 2'd3, 64'h0);   // R1 reset state

        for (int i = 0; i < NVEC; i++) begin
            apply(TBL[i].ctl, TBL[i].wd);
            check_state(int'(TBL[i].req), TBL[i].em, TBL[i].es);
        end

        // R3 read view masking, R2 full machine view
        apply(6'b000010, 64'hFFFF_FFFF_FFFF_E7FF);
        chk(2, "machine view", csr_rdata_o, 64'hFFFF_FFFF_FFFF_E7FF);
        csr_sel_s_i = 1'b1;
        #0.5;
        chk(3, "supervisor view", csr_rdata_o, mask);
        csr_sel_s_i = 1'b0;
        #0.5;

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #0.5;
        rst = 1'b0;
        #0.5;
        check_state(1, 2'd3, 64'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule